// File: doc/BRIEF.md
# Connection CAM command controller

This block keeps a connection table for a time-slot switch and runs the host's table commands against it. The table has three independent groups: even, odd and local. Each group holds `2*HALF_DEPTH` locations, and each location is a valid bit plus a `KEY_W`-bit connection key. The host writes an 8-bit command code, a location field and a data word, and raises a one-cycle strobe. It then reads the result word and two status flags.

There are two kinds of command. Searching commands walk the selected group one location per cycle, lowest index first, and stop at the first hit. These are make-in-first-free-slot, break-by-contents and find-by-contents. Direct commands complete in the strobe cycle. These are clear-by-address, read-by-address, group reset, holding-register reset and full initialize. A busy flag covers a search. A one-cycle done pulse marks the end of every command that is executed.

Top module: `cam_conn_ctrl`

## Requirements
- R1: Codes 0xE0, 0xE1 and 0xE3 make an entry in the even, odd and local group. The data word is stored with its valid bit set in the lowest-index free location of that group. The result word returns that index, and both flags clear.
- R2: A make in a group with no free location writes nothing. It sets the full flag, clears the no-match flag and returns all ones.
- R3: Codes 0xE4, 0xE5 and 0xE7 break an entry. The lowest-index valid location whose key equals the data word is invalidated, and its index is returned. If no location matches, the no-match flag is set and all ones are returned. The full flag clears in both cases.
- R4: Codes 0xF0, 0xF1 and 0xF3 find an entry. They return the lowest-index valid location whose key equals the data word, or all ones with the no-match flag set. The table is not changed.
- R5: Codes 0xE8, 0xE9 and 0xEB clear one location in the lower half of a group. Codes 0xC8, 0xC9 and 0xCB do the same in the upper half. The location index is {upper-half bit, location field}. The clear invalidates that location and clears both flags.
- R6: Codes 0xEC, 0xED, 0xEF (lower half) and 0xCC, 0xCD, 0xCF (upper half) read a location. A valid location returns its key and clears no-match. An invalid location returns all ones and sets no-match. The full flag clears.
- R7: Codes 0xF8, 0xF9 and 0xFB invalidate every location of one group only and clear both flags.
- R8: Code 0xFC sets the result word and both flags to zero and leaves the table intact.
- R9: Code 0xFF invalidates every location of all groups and zeroes the result and flags. Reset leaves the same state, with busy and done low.
- R10: Every other code is reserved. It changes nothing: no done pulse, no busy, and the result, flags and table are unchanged.
- R11: A search whose hit is at index k keeps busy high for k+1 cycles after the strobe edge (a miss takes 2*HALF_DEPTH cycles). Done is high for one cycle as busy falls. A direct command pulses done in the cycle after the strobe and busy stays low.
- R12: A strobe that arrives while busy is high is ignored.
- R13: Each group's contents are independent of commands aimed at the other groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle command strobe |
| mode_in | input | 8 | Command code |
| loc_in | input | $clog2(HALF_DEPTH) | Location within a half, for clear and read |
| data_in | input | KEY_W | Connection key for make, break and find |
| result_out | output | KEY_W | Result word |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| full_flag | output | 1 | Last make found no free location |
| nomatch_flag | output | 1 | Last search or read missed |

## Verification
The make command is tried in several situations. The first makes go into an empty group. Another make follows a break that frees a hole below used locations, which separates lowest-free ordering from append-at-end ordering. The group is then filled until a make reports full. Break and find are run with a key stored twice, which shows that the lowest index wins. They are also run with the same key placed in a different group, which shows the groups are kept apart, and with absent keys, which exercise the miss flag. A strobe is issued while a search is under way. Reserved codes and upper-half clear and read are issued too, and each is followed by reads through the normal command path. These reads show whether the table, result and flags were disturbed.

// File: rtl/cam_conn_pkg.sv
package cam_conn_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_MAKE, OP_BREAK, OP_FIND, OP_CLEAR,
    OP_READ, OP_GRST, OP_HRST, OP_INIT
  } cam_op_e;

  typedef struct packed {
    cam_op_e    op;
    logic [1:0] grp;    // 0 even, 1 odd, 2 local
    logic       upper;  // upper half for clear/read
  } cam_cmd_t;

  // Upper nibble picks the class, low nibble the group or variant.
  function automatic cam_cmd_t decode_mode(input logic [7:0] m);
    cam_cmd_t c;
    logic     gok;
    c.op    = OP_NONE;
    c.upper = 1'b0;
    c.grp   = (m[1:0] == 2'b11) ? 2'd2 : m[1:0];
    gok     = (m[1:0] != 2'b10);
    case (m[7:4])
      4'hE: if (gok) begin
        case (m[3:2])
          2'b00:   c.op = OP_MAKE;
          2'b01:   c.op = OP_BREAK;
          2'b10:   c.op = OP_CLEAR;
          default: c.op = OP_READ;
        endcase
      end
      4'hC: if (gok && m[3]) begin
        c.op    = m[2] ? OP_READ : OP_CLEAR;
        c.upper = 1'b1;
      end
      4'hF: begin
        if (m[3:0] == 4'hC)           c.op = OP_HRST;
        else if (m[3:0] == 4'hF)      c.op = OP_INIT;
        else if (gok && !m[2])        c.op = m[3] ? OP_GRST : OP_FIND;
      end
      default: c.op = OP_NONE;
    endcase
    return c;
  endfunction

  function automatic logic is_scan(input cam_op_e op);
    return (op == OP_MAKE) || (op == OP_BREAK) || (op == OP_FIND);
  endfunction

endpackage

// File: rtl/cam_mode_decode.sv
module cam_mode_decode
  import cam_conn_pkg::*;
(
  input  logic [7:0] mode_i,
  output cam_cmd_t   cmd_o
);
  assign cmd_o = decode_mode(mode_i);
endmodule

// File: rtl/cam_table.sv
module cam_table #(
  parameter int DEPTH = 512,
  parameter int KEY_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NGRP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_grp,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             clr_en,
  input  logic [1:0]       clr_grp,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [NGRP-1:0]  grp_rst,
  input  logic [1:0]       rd_grp,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [KEY_W-1:0] rd_key
);
  logic             gv [NGRP];
  logic [KEY_W-1:0] gk [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [DEPTH-1:0] vld;
    logic [KEY_W-1:0] keys [DEPTH];
    logic             wr_here;
    logic             clr_here;

    assign wr_here  = wr_en  && (wr_grp  == 2'(g));
    assign clr_here = clr_en && (clr_grp == 2'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)           vld <= '0;
      else if (grp_rst[g])  vld <= '0;
      else begin
        if (wr_here)  vld[wr_idx]  <= 1'b1;
        if (clr_here) vld[clr_idx] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) keys[wr_idx] <= wr_key;
    end

    assign gv[g] = vld[rd_idx];
    assign gk[g] = keys[rd_idx];

    // R1
    make_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_here && !grp_rst[g] && !clr_here) |=> vld[$past(wr_idx)]);
  end

  always_comb begin
    case (rd_grp)
      2'd0:    begin rd_vld = gv[0]; rd_key = gk[0]; end
      2'd1:    begin rd_vld = gv[1]; rd_key = gk[1]; end
      default: begin rd_vld = gv[2]; rd_key = gk[2]; end
    endcase
  end
endmodule

// File: rtl/cam_seq.sv
module cam_seq
  import cam_conn_pkg::*;
#(
  parameter int HALF_DEPTH = 256,
  parameter int KEY_W      = 16,
  localparam int LAR_W = $clog2(HALF_DEPTH),
  localparam int DEPTH = 2 * HALF_DEPTH,
  localparam int IDX_W = LAR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  cam_cmd_t         cmd,
  input  logic [LAR_W-1:0] loc_in,
  input  logic [KEY_W-1:0] data_in,
  // table side
  output logic             wr_en,
  output logic [1:0]       wr_grp,
  output logic [IDX_W-1:0] wr_idx,
  output logic [KEY_W-1:0] wr_key,
  output logic             clr_en,
  output logic [1:0]       clr_grp,
  output logic [IDX_W-1:0] clr_idx,
  output logic [2:0]       grp_rst,
  output logic [1:0]       rd_grp,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_vld,
  input  logic [KEY_W-1:0] rd_key,
  // host side
  output logic [KEY_W-1:0] result_q,
  output logic             busy_q,
  output logic             done_q,
  output logic             full_q,
  output logic             nm_q
);
  cam_op_e          op_q;
  logic [1:0]       grp_q;
  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] idx_q;

  // named internal events
  logic             accept;
  logic             scan_hit;
  logic             scan_last;
  logic             finish;
  logic [IDX_W-1:0] host_idx;

  assign host_idx  = {cmd.upper, loc_in};
  assign accept    = cmd_wr && !busy_q && (cmd.op != OP_NONE);
  assign rd_grp    = busy_q ? grp_q : cmd.grp;
  assign rd_idx    = busy_q ? idx_q : host_idx;
  assign scan_hit  = (op_q == OP_MAKE) ? !rd_vld : (rd_vld && (rd_key == key_q));
  assign scan_last = (idx_q == IDX_W'(DEPTH - 1));
  assign finish    = busy_q && (scan_hit || scan_last);

  assign wr_en   = finish && (op_q == OP_MAKE) && scan_hit;
  assign wr_grp  = grp_q;
  assign wr_idx  = idx_q;
  assign wr_key  = key_q;
  assign clr_en  = (finish && (op_q == OP_BREAK) && scan_hit) ||
                   (accept && (cmd.op == OP_CLEAR));
  assign clr_grp = busy_q ? grp_q : cmd.grp;
  assign clr_idx = busy_q ? idx_q : host_idx;

  always_comb begin
    grp_rst = 3'b000;
    if (accept && cmd.op == OP_GRST) grp_rst = 3'(1) << cmd.grp;
    if (accept && cmd.op == OP_INIT) grp_rst = 3'b111;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      full_q   <= 1'b0;
      nm_q     <= 1'b0;
      result_q <= '0;
      op_q     <= OP_NONE;
      grp_q    <= '0;
      key_q    <= '0;
      idx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (finish) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= scan_hit ? KEY_W'(idx_q) : '1;
          full_q   <= (op_q == OP_MAKE) && !scan_hit;
          nm_q     <= (op_q != OP_MAKE) && !scan_hit;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end else if (accept) begin
        done_q <= !is_scan(cmd.op);
        case (cmd.op)
          OP_MAKE, OP_BREAK, OP_FIND: begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            op_q   <= cmd.op;
            grp_q  <= cmd.grp;
            key_q  <= data_in;
          end
          OP_READ: begin
            result_q <= rd_vld ? rd_key : '1;
            nm_q     <= !rd_vld;
            full_q   <= 1'b0;
          end
          OP_HRST, OP_INIT: begin
            result_q <= '0;
            full_q   <= 1'b0;
            nm_q     <= 1'b0;
          end
          default: begin
            full_q <= 1'b0;
            nm_q   <= 1'b0;
          end
        endcase
      end
    end
  end

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  // R11
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (busy_q || done_q));
  // R11
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (idx_q == $past(idx_q) + IDX_W'(1)));
  // R12
  busy_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_wr) |=> ($stable(key_q) && $stable(op_q) && $stable(grp_q)));
  // R10
  reserved_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy_q && cmd.op == OP_NONE) |=>
      (!done_q && !busy_q && $stable(result_q) && $stable(full_q) && $stable(nm_q)));
  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && nm_q));
endmodule

// File: rtl/cam_conn_ctrl.sv
module cam_conn_ctrl
  import cam_conn_pkg::*;
#(
  parameter int HALF_DEPTH = 256,
  parameter int KEY_W      = 16,
  localparam int LAR_W = $clog2(HALF_DEPTH),
  localparam int DEPTH = 2 * HALF_DEPTH,
  localparam int IDX_W = LAR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       mode_in,
  input  logic [LAR_W-1:0] loc_in,
  input  logic [KEY_W-1:0] data_in,
  output logic [KEY_W-1:0] result_out,
  output logic             busy,
  output logic             done,
  output logic             full_flag,
  output logic             nomatch_flag
);
  cam_cmd_t         cmd;
  logic             wr_en, clr_en, rd_vld;
  logic [1:0]       wr_grp, clr_grp, rd_grp;
  logic [IDX_W-1:0] wr_idx, clr_idx, rd_idx;
  logic [KEY_W-1:0] wr_key, rd_key;
  logic [2:0]       grp_rst;

  cam_mode_decode u_dec (.mode_i(mode_in), .cmd_o(cmd));

  cam_table #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_key(wr_key),
    .clr_en(clr_en), .clr_grp(clr_grp), .clr_idx(clr_idx),
    .grp_rst(grp_rst),
    .rd_grp(rd_grp), .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_key(rd_key)
  );

  cam_seq #(.HALF_DEPTH(HALF_DEPTH), .KEY_W(KEY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd),
    .loc_in(loc_in), .data_in(data_in),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_key(wr_key),
    .clr_en(clr_en), .clr_grp(clr_grp), .clr_idx(clr_idx),
    .grp_rst(grp_rst),
    .rd_grp(rd_grp), .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_key(rd_key),
    .result_q(result_out), .busy_q(busy), .done_q(done),
    .full_q(full_flag), .nm_q(nomatch_flag)
  );
endmodule

// File: tb/cam_conn_ctrl_test.sv
`timescale 1ns/1ps
module cam_conn_ctrl_test;
  localparam int HALF = 4;
  localparam int DEP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [7:0]  mode_in = 8'h00;
  logic [1:0]  loc_in = 2'd0;
  logic [15:0] data_in = 16'h0;
  logic [15:0] result_out;
  logic        busy, done, full_flag, nomatch_flag;

  always #2 clk = ~clk;

  cam_conn_ctrl #(.HALF_DEPTH(HALF), .KEY_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .mode_in(mode_in),
    .loc_in(loc_in), .data_in(data_in), .result_out(result_out),
    .busy(busy), .done(done), .full_flag(full_flag), .nomatch_flag(nomatch_flag)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R9";
  bit    cmp_on = 0;

  // behavioural reference model
  bit          mv [3][DEP];
  logic [15:0] mk [3][DEP];
  bit          m_busy = 0, m_done = 0, m_full = 0, m_nm = 0;
  logic [15:0] m_res = 16'h0;
  int          m_cnt = 0, m_hit = -1, m_kind = 0, m_grp = 0;
  logic [15:0] m_key = 16'h0;

  function automatic int grp_of(logic [7:0] m);
    return (m[1:0] == 2'b11) ? 2 : int'(m[1:0]);
  endfunction

  task automatic model_step();
    m_done = 0;
    if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1;
        if (m_hit >= 0) begin
          if (m_kind == 1) begin mv[m_grp][m_hit] = 1; mk[m_grp][m_hit] = m_key; end
          if (m_kind == 2) mv[m_grp][m_hit] = 0;
          m_res = 16'(m_hit);
        end else m_res = 16'hFFFF;
        m_full = (m_kind == 1) && (m_hit < 0);
        m_nm   = (m_kind != 1) && (m_hit < 0);
      end
    end else if (cmd_wr) begin
      int g = grp_of(mode_in);
      int a = int'(loc_in);
      case (mode_in)
        8'hE0, 8'hE1, 8'hE3, 8'hE4, 8'hE5, 8'hE7, 8'hF0, 8'hF1, 8'hF3: begin
          m_kind = (mode_in[7:4] == 4'hF) ? 3 : (mode_in[2] ? 2 : 1);
          m_grp = g; m_key = data_in; m_hit = -1;
          for (int i = DEP - 1; i >= 0; i--) begin
            if (m_kind == 1 && !mv[g][i]) m_hit = i;
            if (m_kind != 1 && mv[g][i] && mk[g][i] == data_in) m_hit = i;
          end
          m_cnt = (m_hit >= 0) ? m_hit + 1 : DEP;
          m_busy = 1;
        end
        8'hE8, 8'hE9, 8'hEB, 8'hC8, 8'hC9, 8'hCB: begin
          if (mode_in[7:4] == 4'hC) a += HALF;
          mv[g][a] = 0; m_full = 0; m_nm = 0; m_done = 1;
        end
        8'hEC, 8'hED, 8'hEF, 8'hCC, 8'hCD, 8'hCF: begin
          if (mode_in[7:4] == 4'hC) a += HALF;
          m_res = mv[g][a] ? mk[g][a] : 16'hFFFF;
          m_nm = !mv[g][a]; m_full = 0; m_done = 1;
        end
        8'hF8, 8'hF9, 8'hFB: begin
          for (int i = 0; i < DEP; i++) mv[g][i] = 0;
          m_full = 0; m_nm = 0; m_done = 1;
        end
        8'hFC: begin m_res = 0; m_full = 0; m_nm = 0; m_done = 1; end
        8'hFF: begin
          for (int j = 0; j < 3; j++) for (int i = 0; i < DEP; i++) mv[j][i] = 0;
          m_res = 0; m_full = 0; m_nm = 0; m_done = 1;
        end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    cmp_on <= 1;
    if (!rst_n) begin
      for (int j = 0; j < 3; j++) for (int i = 0; i < DEP; i++) mv[j][i] = 0;
      m_busy = 0; m_done = 0; m_full = 0; m_nm = 0; m_res = 0;
    end else model_step();
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (busy !== m_busy || done !== m_done || result_out !== m_res ||
          full_flag !== m_full || nomatch_flag !== m_nm) begin
        failures++;
        $display("FAIL %s: cycle compare busy/done/res/full/nm act=%b/%b/%h/%b/%b exp=%b/%b/%h/%b/%b",
                 cur_req, busy, done, result_out, full_flag, nomatch_flag,
                 m_busy, m_done, m_res, m_full, m_nm);
      end
    end
  end

  task automatic expect_res(string req, logic [15:0] exp, bit exp_nm, bit exp_full);
    checks++;
    if (result_out !== exp || nomatch_flag !== exp_nm || full_flag !== exp_full) begin
      failures++;
      $display("FAIL %s: res/nm/full act=%h/%b/%b exp=%h/%b/%b",
               req, result_out, nomatch_flag, full_flag, exp, exp_nm, exp_full);
    end
  endtask

  task automatic issue(string req, logic [7:0] m, logic [1:0] l, logic [15:0] d);
    cur_req = req;
    @(negedge clk);
    mode_in = m; loc_in = l; data_in = d; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_res("R9", 16'h0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 makes into empty groups, R13 other groups
    issue("R1", 8'hE0, 0, 16'h1111); expect_res("R1", 16'd0, 0, 0);
    issue("R1", 8'hE0, 0, 16'h2222); expect_res("R1", 16'd1, 0, 0);
    issue("R1", 8'hE0, 0, 16'h3333); expect_res("R1", 16'd2, 0, 0);
    issue("R13", 8'hE1, 0, 16'hAAAA); expect_res("R13", 16'd0, 0, 0);
    issue("R13", 8'hE3, 0, 16'h5555); expect_res("R13", 16'd0, 0, 0);

    // R6 reads
    issue("R6", 8'hEC, 1, 16'h0); expect_res("R6", 16'h2222, 0, 0);
    issue("R6", 8'hED, 0, 16'h0); expect_res("R6", 16'hAAAA, 0, 0);
    issue("R6", 8'hEC, 3, 16'h0); expect_res("R6", 16'hFFFF, 1, 0);
    issue("R6", 8'hCC, 0, 16'h0); expect_res("R6", 16'hFFFF, 1, 0);

    // R4 find
    issue("R4", 8'hF0, 0, 16'h3333); expect_res("R4", 16'd2, 0, 0);
    issue("R4", 8'hF1, 0, 16'h3333); expect_res("R4", 16'hFFFF, 1, 0);
    issue("R4", 8'hF3, 0, 16'h5555); expect_res("R4", 16'd0, 0, 0);

    // R3 break, lowest-free make after a hole
    issue("R3", 8'hE4, 0, 16'h2222); expect_res("R3", 16'd1, 0, 0);
    issue("R1", 8'hE0, 0, 16'h4444); expect_res("R1", 16'd1, 0, 0);
    issue("R3", 8'hE4, 0, 16'h9999); expect_res("R3", 16'hFFFF, 1, 0);
    issue("R3", 8'hE0, 0, 16'h1111); expect_res("R3", 16'd3, 0, 0);
    issue("R3", 8'hE4, 0, 16'h1111); expect_res("R3", 16'd0, 0, 0);
    issue("R4", 8'hF0, 0, 16'h1111); expect_res("R4", 16'd3, 0, 0);

    // fill even group, then R2 full
    for (int i = 0; i < 5; i++) issue("R1", 8'hE0, 0, 16'h6000 + 16'(i));
    expect_res("R1", 16'd7, 0, 0);
    issue("R2", 8'hE0, 0, 16'hBEEF); expect_res("R2", 16'hFFFF, 0, 1);
    issue("R2", 8'hF0, 0, 16'hBEEF); expect_res("R2", 16'hFFFF, 1, 0);

    // R5 clears, upper and lower half
    issue("R5", 8'hC8, 1, 16'h0);    expect_res("R5", 16'hFFFF, 0, 0);
    issue("R5", 8'hE0, 0, 16'h7777); expect_res("R5", 16'd5, 0, 0);
    issue("R6", 8'hCC, 1, 16'h0);    expect_res("R6", 16'h7777, 0, 0);
    issue("R5", 8'hE8, 2, 16'h0);
    issue("R5", 8'hF0, 0, 16'h3333); expect_res("R5", 16'hFFFF, 1, 0);

    // R12 strobe during a search is ignored
    cur_req = "R12";
    @(negedge clk);
    mode_in = 8'hE0; data_in = 16'h8888; cmd_wr = 1'b1;
    @(negedge clk);
    mode_in = 8'hFF;
    @(negedge clk);
    cmd_wr = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    expect_res("R12", 16'd2, 0, 0);
    issue("R12", 8'hEC, 0, 16'h0); expect_res("R12", 16'h6000, 0, 0);

    // R10 reserved codes
    issue("R10", 8'hE2, 0, 16'h1234);
    issue("R10", 8'hF2, 0, 16'h1234);
    issue("R10", 8'h00, 0, 16'h1234);
    issue("R10", 8'hC0, 0, 16'h1234);
    issue("R10", 8'hFA, 0, 16'h1234);
    issue("R10", 8'hD5, 0, 16'h1234);
    issue("R10", 8'hEA, 0, 16'h1234);
    issue("R10", 8'hC4, 0, 16'h1234);
    expect_res("R10", 16'h6000, 0, 0);
    issue("R10", 8'hEC, 0, 16'h0); expect_res("R10", 16'h6000, 0, 0);

    // R7 group reset on even only
    issue("R7", 8'hF8, 0, 16'h0);
    issue("R7", 8'hEC, 1, 16'h0); expect_res("R7", 16'hFFFF, 1, 0);
    issue("R7", 8'hED, 0, 16'h0); expect_res("R7", 16'hAAAA, 0, 0);
    issue("R13", 8'hF3, 0, 16'h5555); expect_res("R13", 16'd0, 0, 0);

    // R8 holding reset
    issue("R8", 8'hF1, 0, 16'h4321); expect_res("R8", 16'hFFFF, 1, 0);
    issue("R8", 8'hFC, 0, 16'h0);    expect_res("R8", 16'h0, 0, 0);
    issue("R8", 8'hED, 0, 16'h0);    expect_res("R8", 16'hAAAA, 0, 0);

    // R9 initialize
    issue("R9", 8'hFF, 0, 16'h0);    expect_res("R9", 16'h0, 0, 0);
    issue("R9", 8'hF1, 0, 16'hAAAA); expect_res("R9", 16'hFFFF, 1, 0);
    issue("R9", 8'hF3, 0, 16'h5555); expect_res("R9", 16'hFFFF, 1, 0);
    issue("R11", 8'hE3, 0, 16'h0101); expect_res("R11", 16'd0, 0, 0);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule